// File: doc/BRIEF.md
# Word Address Counter With Dual Rollover

This block keeps the current word address of a byte-wide serial memory array of 32768 bytes, grouped as 512 pages of 64 bytes. The protocol engine next to it loads the address in two byte-sized pieces, high part first and low part second. After every data byte it pulses one of two increment strobes. The address is registered and stays put between transactions. A read that sends no address bytes therefore continues from the location after the last byte that was written or read.

The two increment strobes wrap in different ways. A write increment moves only the offset inside the current page, so a long burst of writes cycles around its own 64-byte page. A read increment advances the whole address and runs off the top of the array back to location zero. Loads take priority over increments. Memory access itself happens outside the block.

Top module: `wac_addr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o is 0.
- R2: A load_hi_i pulse stores byte_i[6:0] into addr_o[14:8]. byte_i[7] is ignored and addr_o[7:0] is kept.
- R3: A load_lo_i pulse stores byte_i[7:0] into addr_o[7:0] and keeps addr_o[14:8].
- R4: An inc_wr_i pulse adds one to addr_o[5:0] and leaves addr_o[14:6] unchanged.
- R5: An inc_wr_i pulse with addr_o[5:0] = 63 makes addr_o[5:0] = 0 within the same page.
- R6: An inc_rd_i pulse adds one to the full 15-bit addr_o.
- R7: An inc_rd_i pulse with addr_o = 0x7FFF makes addr_o = 0.
- R8: With no strobe active, addr_o holds its value indefinitely.
- R9: When any load strobe is high, both increment strobes are ignored in that cycle. load_hi_i and load_lo_i together load both parts. When both increment strobes are high without a load, only the write increment applies.
- R10: Every update appears on addr_o one clock edge after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_hi_i | input | 1 | Load the high address part from byte_i |
| load_lo_i | input | 1 | Load the low address byte from byte_i |
| inc_wr_i | input | 1 | Page-local increment after a written byte |
| inc_rd_i | input | 1 | Whole-array increment after a read byte |
| byte_i | input | 8 | Address byte from the protocol engine |
| addr_o | output | 15 | Current word address |

## Verification
The bench builds the counter with its default parameters: a 15-bit address and 6-bit page offset. Both wrap points are therefore the real ones, page offset 63 and address 0x7FFF. Because either address part can be loaded directly, the bench can reach each boundary in a few cycles and does not need thousands of increments. Random mixes of single and simultaneous strobes cover the priority rules.

// File: rtl/wac_pkg.sv
package wac_pkg;
  typedef enum logic [1:0] {
    INC_NONE  = 2'd0,
    INC_PAGE  = 2'd1,
    INC_ARRAY = 2'd2
  } inc_e;

  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
    inc_e inc;
  } wac_op_t;
endpackage

// File: rtl/wac_op_decode.sv
module wac_op_decode
  import wac_pkg::*;
(
  input  logic    load_hi_i,
  input  logic    load_lo_i,
  input  logic    inc_wr_i,
  input  logic    inc_rd_i,
  output wac_op_t op_o
);
  logic any_ld;
  assign any_ld = load_hi_i | load_lo_i;

  always_comb begin
    op_o.ld_hi = load_hi_i;
    op_o.ld_lo = load_lo_i;
    if (any_ld)        op_o.inc = INC_NONE;
    else if (inc_wr_i) op_o.inc = INC_PAGE;
    else if (inc_rd_i) op_o.inc = INC_ARRAY;
    else               op_o.inc = INC_NONE;
  end

  always_comb begin
    if (any_ld) assert (op_o.inc == INC_NONE) else $error("p_ld_prio_r9");
  end
endmodule

// File: rtl/wac_next_addr.sv
module wac_next_addr
  import wac_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAGE_W = 6
) (
  input  logic [ADDR_W-1:0] addr_q_i,
  input  wac_op_t           op_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_d_o
);
  localparam int unsigned HI_W  = ADDR_W - 8;
  localparam int unsigned ROW_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] page_inc, array_inc, loaded;
  logic [PAGE_W-1:0] ofs_inc;

  assign ofs_inc   = addr_q_i[PAGE_W-1:0] + 1'b1;
  assign array_inc = addr_q_i + 1'b1;

  generate
    if (ROW_W > 0) begin : g_rows
      assign page_inc = {addr_q_i[ADDR_W-1:PAGE_W], ofs_inc};
    end else begin : g_flat
      assign page_inc = ofs_inc;
    end
  endgenerate

  assign loaded[7:0]        = op_i.ld_lo ? byte_i : addr_q_i[7:0];
  assign loaded[ADDR_W-1:8] = op_i.ld_hi ? byte_i[HI_W-1:0] : addr_q_i[ADDR_W-1:8];

  always_comb begin
    if (op_i.ld_hi || op_i.ld_lo) addr_d_o = loaded;
    else begin
      unique case (op_i.inc)
        INC_PAGE:  addr_d_o = page_inc;
        INC_ARRAY: addr_d_o = array_inc;
        default:   addr_d_o = addr_q_i;
      endcase
    end
  end
endmodule

// File: rtl/wac_addr_ctr.sv
module wac_addr_ctr
  import wac_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic              inc_wr_i,
  input  logic              inc_rd_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  wac_op_t           op;
  logic [ADDR_W-1:0] addr_q, addr_d;

  wac_op_decode u_dec (
    .load_hi_i(load_hi_i),
    .load_lo_i(load_lo_i),
    .inc_wr_i (inc_wr_i),
    .inc_rd_i (inc_rd_i),
    .op_o     (op)
  );

  wac_next_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_nxt (
    .addr_q_i(addr_q),
    .op_i    (op),
    .byte_i  (byte_i),
    .addr_d_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  logic any_strobe, only_wr, only_rd;
  assign any_strobe = load_hi_i | load_lo_i | inc_wr_i | inc_rd_i;
  assign only_wr    = inc_wr_i & ~load_hi_i & ~load_lo_i;
  assign only_rd    = inc_rd_i & ~inc_wr_i & ~load_hi_i & ~load_lo_i;

  always_comb begin
    if (!rst_ni) assert (addr_o == '0) else $error("p_reset_zero_r1");
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_strobe |=> $stable(addr_o));

  p_wr_row_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_wr |=> $stable(addr_o[ADDR_W-1:PAGE_W]));

  p_wr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_wr && addr_o[PAGE_W-1:0] == '1) |=> addr_o[PAGE_W-1:0] == '0);

  p_rd_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_rd && addr_o == '1) |=> addr_o == '0);

  p_lo_keep_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_lo_i && !load_hi_i) |=> $stable(addr_o[ADDR_W-1:8]));

  p_hi_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hi_i |=> addr_o[ADDR_W-1:8] == $past(byte_i[HI_W-1:0]));
endmodule

// File: tb/wac_addr_ctr_tb.sv
module wac_addr_ctr_tb_top;
  localparam int AW = 15;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_hi = 1'b0, load_lo = 1'b0, inc_wr = 1'b0, inc_rd = 1'b0;
  logic [7:0] byte_v = '0;
  logic [AW-1:0] addr;
  logic [AW-1:0] model = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wac_addr_ctr #(.ADDR_W(AW), .PAGE_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_hi_i(load_hi), .load_lo_i(load_lo),
    .inc_wr_i(inc_wr), .inc_rd_i(inc_rd), .byte_i(byte_v), .addr_o(addr)
  );

  function automatic logic [AW-1:0] next_model(logic [AW-1:0] cur, logic lh, logic ll,
                                               logic iw, logic ir, logic [7:0] b);
    logic [AW-1:0] n = cur;
    if (lh || ll) begin
      if (lh) n[AW-1:8] = b[AW-9:0];
      if (ll) n[7:0] = b;
    end else if (iw) begin
      n[PW-1:0] = cur[PW-1:0] + 1'b1;
    end else if (ir) begin
      n = cur + 1'b1;
    end
    return n;
  endfunction

  function automatic string tag_of(logic [AW-1:0] cur, logic lh, logic ll, logic iw, logic ir);
    if ((lh || ll) && (iw || ir)) return "R9";
    if (lh && ll) return "R9";
    if (lh) return "R2";
    if (ll) return "R3";
    if (iw && ir) return "R9";
    if (iw) return (cur[PW-1:0] == '1) ? "R5" : "R4";
    if (ir) return (cur == '1) ? "R7" : "R6";
    return "R8";
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    checks++;
    if (addr !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  // R10: drive at negedge, sample 1 ns after the following posedge
  task automatic step(logic lh, logic ll, logic iw, logic ir, logic [7:0] b);
    string t;
    @(negedge clk);
    load_hi = lh; load_lo = ll; inc_wr = iw; inc_rd = ir; byte_v = b;
    t = tag_of(model, lh, ll, iw, ir);
    model = next_model(model, lh, ll, iw, ir, b);
    @(posedge clk); #1;
    check(t, model);
    @(negedge clk);
    load_hi = 0; load_lo = 0; inc_wr = 0; inc_rd = 0;
  endtask

  task automatic load(logic [AW-1:0] a);
    step(1, 0, 0, 0, {1'b1, a[AW-1:8]});   // bit 7 set: must be ignored (R2)
    step(0, 1, 0, 0, a[7:0]);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: addr=%h expected=done", addr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    #7; check("R1", '0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1; check("R1", '0);

    load(15'h1234);
    step(0, 0, 0, 0, 8'hff); check("R8", 15'h1234);
    load(15'h12bf);                              // offset 63 in its page
    step(0, 0, 1, 0, 0);                         // R5 wrap to 0x1280
    check("R5", 15'h1280);
    step(0, 0, 1, 0, 0);                         // R4
    load(15'h7fff);
    step(0, 0, 0, 1, 0);                         // R7
    check("R7", 15'h0000);
    load(15'h00ff);
    step(0, 0, 0, 1, 0);                         // R6 carry into upper bits
    check("R6", 15'h0100);
    step(0, 0, 1, 1, 0);                         // R9 write wins
    step(1, 1, 1, 1, 8'h55);                     // R9 loads win
    check("R9", 15'h5555);
    repeat (5) step(0, 0, 0, 0, 8'h00);          // R8

    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [7:0] b = 8'($urandom);
      if (r < 8)       step(1, 0, 0, 0, b);
      else if (r < 16) step(0, 1, 0, 0, b);
      else if (r < 50) step(0, 0, 1, 0, b);
      else if (r < 84) step(0, 0, 0, 1, b);
      else if (r < 92) step(0, 0, 0, 0, b);
      else             step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), b);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule